// File: doc/BRIEF.md
# Programmable Priority Interrupt Arbiter

This block gathers level-sensitive interrupt requests from a set of peripheral sources and picks one winner each clock cycle. Sources are organised in groups of two. Each group is given a 4-bit priority level through a small register file that software reads and writes. The winner is the active, unmasked request with the highest level. When several requests share that level, the one with the lowest source index wins. The winner's level is then compared against the 4-bit mask level supplied by the CPU. A request is raised towards the CPU only when the winner's level is strictly greater than the mask level.

Every source also has a mask bit. This bit is set through one register address and cleared through another. This lets software set or clear any subset of mask bits with a single write, without a read-modify-write. Requests are not stored anywhere in the block. A source that drops its request stops competing on the next decision. The winning level, the source code and the CPU request are all registered, so each decision appears exactly one clock after the inputs it was made from.

Top module: `irq_arb_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `irq_req`, `irq_level` and `irq_code` are 0. All priority levels and all mask bits reset to 0.
- R2: Three priority registers sit at addresses 0, 1 and 2. Group g (sources 2g and 2g+1) takes its level from register g/4, bits [4*(g%4)+3 : 4*(g%4)]. A read returns the stored fields, and bits 31:16 read as 0.
- R3: Among the unmasked sources that request with a nonzero level, `irq_level` carries the highest level and `irq_code` carries that source's index.
- R4: When several candidates share the highest level, the lowest source index wins. This applies both across groups and within one group.
- R5: A source whose group level is 0 never wins. When no source qualifies, `irq_level` and `irq_code` are 0.
- R6: `irq_req` is 1 exactly when the registered winner level is strictly greater than the `cpu_mask` value sampled at the same edge.
- R7: Writing address 3 sets mask bit i for every 1 in `reg_wdata[i]` (bits 23:0). Bits written as 0 are unchanged. A masked source never wins.
- R8: Writing address 4 clears mask bit i for every 1 in `reg_wdata[i]`. Bits written as 0 are unchanged. Reads of address 3 and of address 4 both return the current mask in bits 23:0, with bits 31:24 as 0.
- R9: No request is latched. A source that drops its request no longer appears in the decision made from the next sampled inputs.
- R10: The outputs change only at a rising edge and reflect the inputs and register contents sampled at that edge. A read of addresses 5 to 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 24 | Level request per source |
| cpu_mask | input | 4 | CPU interrupt mask level |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_req | output | 1 | Request to the CPU |
| irq_level | output | 4 | Level of the current winner |
| irq_code | output | 5 | Source index of the current winner |

## Verification
Requests and the CPU mask sampled at an edge show up on `irq_level`, `irq_code` and `irq_req` right after that edge, one cycle later. A register write takes effect in the decision made at the following edge, two cycles after it is driven. Read data follows the address and the register contents with no delay. The bench drives inputs on falling edges and computes the expected decision from the model state in force before the write of that cycle. It then compares on the next falling edge. A directed step also confirms that the outputs hold their old value just before the sampling edge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int LVL_W       = 4;
    localparam int SRC_PER_GRP = 2;
    localparam int FLD_PER_REG = 4;
    localparam int NUM_PRI_REG = 3;
    localparam int NUM_GROUPS  = NUM_PRI_REG * FLD_PER_REG;
    localparam int NUM_SRC     = NUM_GROUPS * SRC_PER_GRP;
    localparam int CODE_W      = $clog2(NUM_SRC);
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 3;

    typedef enum logic [ADDR_W-1:0] {
        ADR_PRI0 = 3'd0,
        ADR_PRI1 = 3'd1,
        ADR_PRI2 = 3'd2,
        ADR_MSET = 3'd3,
        ADR_MCLR = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic [LVL_W-1:0]  lvl;
        logic [CODE_W-1:0] code;
    } win_t;

    function automatic int grp_of(input int src);
        return src / SRC_PER_GRP;
    endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_arb_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [ADDR_W-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [NUM_GROUPS-1:0][LVL_W-1:0]  grp_lvl,
    output logic [NUM_SRC-1:0]                mask,
    output logic [DATA_W-1:0]                 rdata
);
    localparam int REG_BITS = FLD_PER_REG * LVL_W;

    logic [NUM_GROUPS-1:0][LVL_W-1:0] lvl_q;
    logic [NUM_SRC-1:0]               mask_q;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        localparam int REG_IDX = g / FLD_PER_REG;
        localparam int LSB     = (g % FLD_PER_REG) * LVL_W;
        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q[g] <= '0;
            end else if (we && addr == ADR_PRI0 + ADDR_W'(REG_IDX)) begin
                lvl_q[g] <= wdata[LSB +: LVL_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (we && addr == ADR_MSET) begin
            mask_q <= mask_q | wdata[NUM_SRC-1:0];
        end else if (we && addr == ADR_MCLR) begin
            mask_q <= mask_q & ~wdata[NUM_SRC-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_PRI0, ADR_PRI1, ADR_PRI2: begin
                for (int f = 0; f < FLD_PER_REG; f++) begin
                    rdata[f*LVL_W +: LVL_W] = lvl_q[int'(addr) * FLD_PER_REG + f];
                end
            end
            ADR_MSET, ADR_MCLR: rdata[NUM_SRC-1:0] = mask_q;
            default: rdata = '0;
        endcase
        rdata[DATA_W-1:REG_BITS] = (addr == ADR_MSET || addr == ADR_MCLR) ?
            rdata[DATA_W-1:REG_BITS] : '0;
    end

    assign grp_lvl = lvl_q;
    assign mask    = mask_q;
endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_arb_pkg::*;
(
    input  logic [NUM_SRC-1:0]               req,
    input  logic [NUM_SRC-1:0]               mask,
    input  logic [NUM_GROUPS-1:0][LVL_W-1:0] grp_lvl,
    output win_t                             win
);
    logic [NUM_SRC-1:0][LVL_W-1:0] eff_lvl;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign eff_lvl[s] = (req[s] && !mask[s]) ? grp_lvl[grp_of(s)] : '0;
    end

    always_comb begin
        win = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (eff_lvl[s] > win.lvl) begin
                win.lvl  = eff_lvl[s];
                win.code = CODE_W'(s);
            end
        end
    end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
    import irq_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  win_t             win,
    input  logic [LVL_W-1:0] cpu_mask,
    output win_t             win_q,
    output logic             req_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= '0;
            req_q <= 1'b0;
        end else begin
            win_q <= win;
            req_q <= (win.lvl > cpu_mask);
        end
    end
endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
    import irq_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_req,
    input  logic [LVL_W-1:0]    cpu_mask,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                irq_req,
    output logic [LVL_W-1:0]    irq_level,
    output logic [CODE_W-1:0]   irq_code
);
    logic [NUM_GROUPS-1:0][LVL_W-1:0] grp_lvl;
    logic [NUM_SRC-1:0]               mask_q;
    win_t                             win_d;
    win_t                             win_q;

    irq_prio_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .grp_lvl (grp_lvl),
        .mask    (mask_q),
        .rdata   (reg_rdata)
    );

    irq_select u_sel (
        .req     (src_req),
        .mask    (mask_q),
        .grp_lvl (grp_lvl),
        .win     (win_d)
    );

    irq_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .win      (win_d),
        .cpu_mask (cpu_mask),
        .win_q    (win_q),
        .req_q    (irq_req)
    );

    assign irq_level = win_q.lvl;
    assign irq_code  = win_q.code;
endmodule

// File: rtl/irq_arb_sva.sv
module irq_arb_sva
    import irq_arb_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [NUM_SRC-1:0]  src_req,
    input logic [LVL_W-1:0]    cpu_mask,
    input logic                reg_we,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [NUM_SRC-1:0]  mask,
    input logic                irq_req,
    input logic [LVL_W-1:0]    irq_level,
    input logic [CODE_W-1:0]   irq_code
);
    logic [NUM_SRC-1:0] req_d;
    logic [NUM_SRC-1:0] mask_d;

    always_ff @(posedge clk) begin
        req_d  <= src_req;
        mask_d <= mask;
    end

    AST_REQ_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (irq_level > $past(cpu_mask)));  // R6

    AST_WINNER_WAS_ASKING: assert property (@(posedge clk) disable iff (rst)
        (irq_level != '0) |-> (((req_d >> irq_code) & NUM_SRC'(1)) != '0));  // R9

    AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        (irq_level != '0) |-> (((mask_d >> irq_code) & NUM_SRC'(1)) == '0));  // R7

    AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (irq_level == '0) |-> (irq_code == '0 && !irq_req));  // R5

    AST_MSET_SETS: assert property (@(posedge clk) disable iff (rst)
        $past(reg_we && reg_addr == ADR_MSET) |->
            ((mask & $past(reg_wdata[NUM_SRC-1:0])) == $past(reg_wdata[NUM_SRC-1:0])));  // R7

    AST_MCLR_CLEARS_ONLY: assert property (@(posedge clk) disable iff (rst)
        $past(reg_we && reg_addr == ADR_MCLR) |->
            ((mask & ($past(reg_wdata[NUM_SRC-1:0]) | ~$past(mask))) == '0));  // R8
endmodule

bind irq_arb_top irq_arb_sva u_sva (
    .clk       (clk),
    .rst       (rst),
    .src_req   (src_req),
    .cpu_mask  (cpu_mask),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mask      (mask_q),
    .irq_req   (irq_req),
    .irq_level (irq_level),
    .irq_code  (irq_code)
);

// File: tb/tb_irq_arb_top.sv
`timescale 1ns/1ps
module tb_irq_arb_top;
    import irq_arb_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NUM_SRC-1:0]  src_req = '0;
    logic [LVL_W-1:0]    cpu_mask = '0;
    logic                reg_we = 1'b0;
    logic [ADDR_W-1:0]   reg_addr = '0;
    logic [DATA_W-1:0]   reg_wdata = '0;
    logic [DATA_W-1:0]   reg_rdata;
    logic                irq_req;
    logic [LVL_W-1:0]    irq_level;
    logic [CODE_W-1:0]   irq_code;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [LVL_W-1:0]   m_lvl [NUM_GROUPS];
    logic [NUM_SRC-1:0] m_mask;

    always #2.5 clk = ~clk;

    irq_arb_top dut (
        .clk(clk), .rst(rst), .src_req(src_req), .cpu_mask(cpu_mask),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_level(irq_level),
        .irq_code(irq_code)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a);
        logic [31:0] r = '0;
        if (a <= 3'd2) begin
            for (int f = 0; f < FLD_PER_REG; f++)
                r[f*LVL_W +: LVL_W] = m_lvl[int'(a)*FLD_PER_REG + f];
        end else if (a == 3'd3 || a == 3'd4) begin
            r[NUM_SRC-1:0] = m_mask;
        end
        return r;
    endfunction

    function automatic logic [9:0] model_arb(input logic [NUM_SRC-1:0] rq, input logic [3:0] cm);
        logic [3:0] best = '0;
        logic [4:0] code = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (rq[s] && !m_mask[s] && m_lvl[s/2] > best) begin
                best = m_lvl[s/2];
                code = 5'(s);
            end
        end
        return {(best > cm), best, code};
    endfunction

    task automatic model_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        if (a <= 3'd2) begin
            for (int f = 0; f < FLD_PER_REG; f++)
                m_lvl[int'(a)*FLD_PER_REG + f] = d[f*LVL_W +: LVL_W];
        end else if (a == 3'd3) begin
            m_mask = m_mask | d[NUM_SRC-1:0];
        end else if (a == 3'd4) begin
            m_mask = m_mask & ~d[NUM_SRC-1:0];
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        model_write(a, d);
        reg_we = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic apply(input string tag, input logic [NUM_SRC-1:0] rq, input logic [3:0] cm,
                         input logic ereq, input logic [3:0] elvl, input logic [4:0] ecode);
        src_req = rq; cpu_mask = cm;
        step();
        check({tag, " irq_level"}, 32'(irq_level), 32'(elvl));
        check({tag, " irq_code"}, 32'(irq_code), 32'(ecode));
        check({tag, " irq_req"}, 32'(irq_req), 32'(ereq));
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
                $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [9:0] exp_v;
        bit have_exp;
        void'($urandom(32'd24681));
        for (int g = 0; g < NUM_GROUPS; g++) m_lvl[g] = '0;
        m_mask = '0;

        // R1: reset state
        @(negedge clk);
        src_req = '1; cpu_mask = '0;
        step();
        check("R1 level in reset", 32'(irq_level), 0);
        check("R1 req in reset", 32'(irq_req), 0);
        rst = 1'b0;
        src_req = '0;
        #1;
        check("R1 code after reset", 32'(irq_code), 0);
        rd("R1 pri0 reset", 3'd0, 0);
        rd("R1 mask reset", 3'd3, 0);

        // R2: priority fields and reserved bits
        wr(3'd0, 32'hFFFF_4321);
        wr(3'd1, 32'h0000_0044);
        wr(3'd2, 32'h0000_0000);
        rd("R2 pri0 readback", 3'd0, 32'h0000_4321);
        rd("R2 pri1 readback", 3'd1, 32'h0000_0044);

        // R3: highest level wins
        apply("R3 two levels", 24'h000005, 4'd0, 1'b1, 4'd2, 5'd2);
        apply("R3 three levels", 24'h000015, 4'd0, 1'b1, 4'd3, 5'd4);
        // R4: ties resolved by lowest index
        apply("R4 tie across groups", 24'h0001C0, 4'd0, 1'b1, 4'd4, 5'd6);
        apply("R4 tie other order", 24'h000280, 4'd0, 1'b1, 4'd4, 5'd7);
        // R5: level 0 disables
        apply("R5 disabled only", 24'h100000, 4'd0, 1'b0, 4'd0, 5'd0);
        apply("R5 disabled plus low", 24'h100001, 4'd0, 1'b1, 4'd1, 5'd0);
        // R6: strict compare
        apply("R6 equal to mask", 24'h000010, 4'd3, 1'b0, 4'd3, 5'd4);
        apply("R6 above mask", 24'h000010, 4'd2, 1'b1, 4'd3, 5'd4);
        apply("R6 mask 15", 24'h000040, 4'd15, 1'b0, 4'd4, 5'd6);
        // R7: mask set
        wr(3'd3, 32'h0000_0044);
        rd("R7 mask set readback", 3'd3, 32'h0000_0044);
        apply("R7 masked sources skipped", 24'h000054, 4'd0, 1'b1, 4'd3, 5'd4);
        // R8: mask clear, zero bits untouched
        wr(3'd4, 32'h0000_0040);
        rd("R8 mask after clear", 3'd3, 32'h0000_0004);
        rd("R8 clear addr reads mask", 3'd4, 32'h0000_0004);
        apply("R8 unmasked source wins", 24'h000044, 4'd0, 1'b1, 4'd4, 5'd6);
        // R9: no latching
        apply("R9 request present", 24'h000080, 4'd0, 1'b1, 4'd4, 5'd7);
        apply("R9 request dropped", 24'h000000, 4'd0, 1'b0, 4'd0, 5'd0);
        // R10: latency and unused addresses
        src_req = 24'h000001;
        #1;
        check("R10 no change before edge", 32'(irq_level), 0);
        step();
        check("R10 change after edge", 32'(irq_level), 1);
        rd("R10 unused addr5", 3'd5, 0);
        rd("R10 unused addr7", 3'd7, 0);

        // random phase
        have_exp = 1'b0;
        exp_v = '0;
        for (int n = 0; n < 4000; n++) begin
            if (have_exp) begin
                check("R3 random level", 32'(irq_level), 32'(exp_v[8:5]));
                check("R4 random code", 32'(irq_code), 32'(exp_v[4:0]));
                check("R6 random req", 32'(irq_req), 32'(exp_v[9]));
                check("R8 random read", reg_rdata, model_read(reg_addr));
            end
            src_req  = NUM_SRC'($urandom & $urandom);
            cpu_mask = 4'($urandom);
            reg_we   = ($urandom % 6) == 0;
            reg_addr = 3'($urandom % 6);
            reg_wdata = $urandom;
            if (reg_addr == 3'd3) reg_wdata = reg_wdata & $urandom & $urandom;
            exp_v = model_arb(src_req, cpu_mask);
            if (reg_we) model_write(reg_addr, reg_wdata);
            have_exp = 1'b1;
            step();
        end
        reg_we = 1'b0;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule